// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides whether a new thread block may be placed on one streaming multiprocessor. It keeps three running totals: resident blocks, resident threads and allocated registers. A block's register cost is its thread count multiplied by its registers per thread. A request is granted only if, after the block is added, the block count, the thread count and the register count all stay within their limits. A granted block holds a slot, and its thread and register reservations belong to that slot alone until the slot is released.

Requests use a valid/ready handshake. The answer arrives one cycle after acceptance as a single-cycle grant pulse. The pulse carries a granted or refused flag and, on a grant, the slot index. A refused request is dropped, and the requester must try again later.

A release port gives back everything a slot held. A separate query port reports how many more blocks of a given shape would still fit.

Top module: `blk_admit_ctrl`

## Requirements
- R1: During synchronous reset and in the cycle after it, no slot is occupied, `gnt_valid` is low and `req_ready` is low. From the first clock edge after reset, `req_ready` is high. With nothing resident, the query for 256 threads at 10 registers each reports 3.
- R2: A request with 0 threads, or with more than 512 threads, is refused. The query reports 0 for such a shape.
- R3: At most 8 blocks are resident at once. A ninth request is refused even if threads and registers remain.
- R4: At most 768 threads are resident at once. A request that would push the total past 768 is refused.
- R5: A block reserves threads × registers-per-thread registers from a pool of 8192. A request that would exceed the pool is refused. For example, 256 threads at 10 registers fit 3 times, and 256 threads at 11 registers fit 2 times.
- R6: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. On the next cycle `gnt_valid` is high for exactly one cycle. `gnt_ok` is 1 for a grant and 0 for a refusal. On a grant, `gnt_slot` is the lowest-numbered free slot.
- R7: A release of an occupied slot returns that slot, its threads and its registers. A release naming an unoccupied slot has no effect.
- R8: When a release and a request arrive on the same edge, the admission decision uses the occupancy from before the release. Both updates are applied on that edge.
- R9: A refused request is not kept. No grant pulse appears on any cycle that does not follow an accepted request.
- R10: `fit_count` is registered. It is the largest k (0 to 8) such that k more blocks of the queried shape stay within all three limits, computed from the state and query present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Admission request present |
| req_ready | output | 1 | Request can be accepted |
| req_threads | input | 10 | Threads in the requested block |
| req_regs | input | 8 | Registers per thread |
| gnt_valid | output | 1 | One-cycle answer pulse |
| gnt_ok | output | 1 | 1 = granted, 0 = refused |
| gnt_slot | output | 3 | Slot assigned on a grant |
| rel_valid | input | 1 | Release request |
| rel_slot | input | 3 | Slot to release |
| qry_threads | input | 10 | Query shape: threads per block |
| qry_regs | input | 8 | Query shape: registers per thread |
| fit_count | output | 4 | Number of further blocks of the query shape that fit |

## Verification
Admission and release can fall in the same cycle. The bench fills all eight slots and then raises a release of slot 6 and a new request on the same edge. It expects a refusal, because the decision sees the full state from before the release. It then expects a fit count of 1 and a grant of slot 6 on the following request. This shows that the freed resources were returned and that the blocked request was not silently taken.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  // Register cost of one block: threads times registers per thread.
  function automatic logic [31:0] blk_cost(input logic [31:0] thr, input logic [31:0] rpt);
    return thr * rpt;
  endfunction

  // Thread count legal for a single block.
  function automatic logic thr_legal(input logic [31:0] thr, input logic [31:0] max_thr);
    return (thr != 32'd0) && (thr <= max_thr);
  endfunction
endpackage

// File: rtl/blk_slot_table.sv
module blk_slot_table #(
  parameter int NSLOT = 8,
  parameter int TW    = 10,
  parameter int RGW   = 14,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_en,
  input  logic [SW-1:0]  alloc_slot,
  input  logic [TW-1:0]  alloc_thr,
  input  logic [RGW-1:0] alloc_regs,
  input  logic           rel_en,
  input  logic [SW-1:0]  rel_slot,
  output logic [SW-1:0]  free_slot,
  output logic           any_free,
  output logic           rel_hit,
  output logic [TW-1:0]  rel_thr,
  output logic [RGW-1:0] rel_regs
);
  logic [NSLOT-1:0] occ;
  logic [TW-1:0]    thr_mem [NSLOT];
  logic [RGW-1:0]   reg_mem [NSLOT];

  // Lowest free slot: scan from the top so the lowest index wins.
  always_comb begin
    free_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!occ[i]) free_slot = SW'(i);
    end
    any_free = ~&occ;
  end

  assign rel_hit  = rel_en && occ[rel_slot];
  assign rel_thr  = thr_mem[rel_slot];
  assign rel_regs = reg_mem[rel_slot];

  // Per-slot storage: plain synchronous write, no reset.
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      thr_mem[alloc_slot] <= alloc_thr;
      reg_mem[alloc_slot] <= alloc_regs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (alloc_en && alloc_slot == SW'(i))    occ[i] <= 1'b1;
        else if (rel_hit && rel_slot == SW'(i))  occ[i] <= 1'b0;
      end
    end
  end

  // R6: an allocation never lands on a slot that is already held.
  a_r6_alloc_free_slot: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !occ[alloc_slot]);

  // R7: a released slot is empty on the next cycle.
  a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
    (rel_hit && !alloc_en) |=> !occ[$past(rel_slot)]);
endmodule

// File: rtl/blk_fit_calc.sv
module blk_fit_calc
  import blk_admit_pkg::*;
#(
  parameter int MAX_BLOCKS      = 8,
  parameter int MAX_THREADS     = 768,
  parameter int REG_POOL        = 8192,
  parameter int MAX_BLK_THREADS = 512,
  parameter int TW              = 10,
  parameter int RPT_W           = 8,
  parameter int BW              = 4,
  parameter int THW             = 10,
  parameter int RGW             = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BW-1:0]    used_blk,
  input  logic [THW-1:0]   used_thr,
  input  logic [RGW-1:0]   used_reg,
  input  logic [TW-1:0]    qry_threads,
  input  logic [RPT_W-1:0] qry_regs,
  output logic [BW-1:0]    fit_count
);
  logic [MAX_BLOCKS-1:0] k_fits;
  logic [31:0]           q_cost;
  logic                  q_legal;

  assign q_cost  = blk_cost(32'(qry_threads), 32'(qry_regs));
  assign q_legal = thr_legal(32'(qry_threads), 32'(MAX_BLK_THREADS));

  // Each candidate k is tested against all three limits in parallel.
  for (genvar k = 1; k <= MAX_BLOCKS; k++) begin : g_k
    assign k_fits[k-1] = q_legal
      && (32'(used_blk) + 32'(k) <= 32'(MAX_BLOCKS))
      && (32'(used_thr) + 32'(k) * 32'(qry_threads) <= 32'(MAX_THREADS))
      && (32'(used_reg) + 32'(k) * q_cost <= 32'(REG_POOL));
  end

  always_ff @(posedge clk) begin
    if (rst) fit_count <= '0;
    else     fit_count <= BW'($countones(k_fits));
  end

  // R2: an illegal query shape reports nothing fitting.
  a_r2_fit_zero_illegal: assert property (@(posedge clk) disable iff (rst)
    (qry_threads == '0) |=> (fit_count == '0));
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
  import blk_admit_pkg::*;
#(
  parameter int MAX_BLOCKS      = 8,
  parameter int MAX_THREADS     = 768,
  parameter int REG_POOL        = 8192,
  parameter int MAX_BLK_THREADS = 512,
  parameter int RPT_W           = 8,
  localparam int TW  = $clog2(MAX_BLK_THREADS + 1),
  localparam int SW  = $clog2(MAX_BLOCKS),
  localparam int BW  = $clog2(MAX_BLOCKS + 1),
  localparam int THW = $clog2(MAX_THREADS + 1),
  localparam int RGW = $clog2(REG_POOL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TW-1:0]    req_threads,
  input  logic [RPT_W-1:0] req_regs,
  output logic             gnt_valid,
  output logic             gnt_ok,
  output logic [SW-1:0]    gnt_slot,
  input  logic             rel_valid,
  input  logic [SW-1:0]    rel_slot,
  input  logic [TW-1:0]    qry_threads,
  input  logic [RPT_W-1:0] qry_regs,
  output logic [BW-1:0]    fit_count
);
  logic [BW-1:0]  used_blk;
  logic [THW-1:0] used_thr;
  logic [RGW-1:0] used_reg;

  logic           take, fits, grant;
  logic [31:0]    cost;
  logic [SW-1:0]  free_slot;
  logic           any_free, rel_hit;
  logic [TW-1:0]  rel_thr;
  logic [RGW-1:0] rel_regs;

  assign take = req_valid && req_ready;
  assign cost = blk_cost(32'(req_threads), 32'(req_regs));
  // Decision sees the occupancy from before any same-cycle release.
  assign fits = thr_legal(32'(req_threads), 32'(MAX_BLK_THREADS))
             && any_free
             && (32'(used_thr) + 32'(req_threads) <= 32'(MAX_THREADS))
             && (32'(used_reg) + cost <= 32'(REG_POOL));
  assign grant = take && fits;

  blk_slot_table #(.NSLOT(MAX_BLOCKS), .TW(TW), .RGW(RGW)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (grant),
    .alloc_slot (free_slot),
    .alloc_thr  (req_threads),
    .alloc_regs (RGW'(cost)),
    .rel_en     (rel_valid),
    .rel_slot   (rel_slot),
    .free_slot  (free_slot),
    .any_free   (any_free),
    .rel_hit    (rel_hit),
    .rel_thr    (rel_thr),
    .rel_regs   (rel_regs)
  );

  blk_fit_calc #(
    .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL),
    .MAX_BLK_THREADS(MAX_BLK_THREADS), .TW(TW), .RPT_W(RPT_W),
    .BW(BW), .THW(THW), .RGW(RGW)
  ) u_fit (
    .clk         (clk),
    .rst         (rst),
    .used_blk    (used_blk),
    .used_thr    (used_thr),
    .used_reg    (used_reg),
    .qry_threads (qry_threads),
    .qry_regs    (qry_regs),
    .fit_count   (fit_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      gnt_valid <= 1'b0;
      gnt_ok    <= 1'b0;
      gnt_slot  <= '0;
      used_blk  <= '0;
      used_thr  <= '0;
      used_reg  <= '0;
    end else begin
      req_ready <= 1'b1;
      gnt_valid <= take;
      gnt_ok    <= grant;
      if (take) gnt_slot <= free_slot;
      used_blk <= used_blk + (grant ? BW'(1) : BW'(0))
                           - (rel_hit ? BW'(1) : BW'(0));
      used_thr <= used_thr + (grant ? THW'(req_threads) : THW'(0))
                           - (rel_hit ? THW'(rel_thr) : THW'(0));
      used_reg <= used_reg + (grant ? RGW'(cost) : RGW'(0))
                           - (rel_hit ? rel_regs : RGW'(0));
    end
  end

  // R3: the block counter agrees with the slot table's occupancy.
  a_r3_blk_sync: assert property (@(posedge clk) disable iff (rst)
    (used_blk == BW'(MAX_BLOCKS)) == !any_free);
  // R4: resident threads never exceed the cap.
  a_r4_thr_cap: assert property (@(posedge clk) disable iff (rst)
    32'(used_thr) <= 32'(MAX_THREADS));
  // R5: allocated registers never exceed the pool.
  a_r5_reg_cap: assert property (@(posedge clk) disable iff (rst)
    32'(used_reg) <= 32'(REG_POOL));
  // R9: no answer pulse without an accepted request one cycle earlier.
  a_r9_no_stray_gnt: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !gnt_valid);
endmodule

// File: tb/blk_admit_ctrl_test.sv
`timescale 1ns/1ps
module blk_admit_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [9:0] req_threads = '0;
  logic [7:0] req_regs = '0;
  logic       gnt_valid, gnt_ok;
  logic [2:0] gnt_slot;
  logic       rel_valid = 1'b0;
  logic [2:0] rel_slot = '0;
  logic [9:0] qry_threads = '0;
  logic [7:0] qry_regs = '0;
  logic [3:0] fit_count;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  blk_admit_ctrl uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs(req_regs),
    .gnt_valid(gnt_valid), .gnt_ok(gnt_ok), .gnt_slot(gnt_slot),
    .rel_valid(rel_valid), .rel_slot(rel_slot),
    .qry_threads(qry_threads), .qry_regs(qry_regs),
    .fit_count(fit_count)
  );

  // Vector: {threads[9:0], regs[7:0], ok, slot[2:0]} from an empty state.
  localparam logic [21:0] VEC [6] = '{
    {10'd256, 8'd10, 1'b1, 3'd0},
    {10'd256, 8'd10, 1'b1, 3'd1},
    {10'd256, 8'd10, 1'b1, 3'd2},
    {10'd1,   8'd1,  1'b0, 3'd0},
    {10'd0,   8'd1,  1'b0, 3'd0},
    {10'd513, 8'd0,  1'b0, 3'd0}
  };

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int t, input int r, input bit ok, input int slot, input string tag);
    int act, exp;
    @(negedge clk);
    req_valid = 1'b1; req_threads = 10'(t); req_regs = 8'(r);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    act = {gnt_valid, gnt_ok, (ok ? gnt_slot : 3'd0)};
    exp = {1'b1, ok, (ok ? 3'(slot) : 3'd0)};
    check(act == exp, tag, act, exp);
  endtask

  task automatic do_rel(input int slot);
    @(negedge clk);
    rel_valid = 1'b1; rel_slot = 3'(slot);
    @(posedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic chk_fit(input int t, input int r, input int exp, input string tag);
    @(negedge clk);
    qry_threads = 10'(t); qry_regs = 8'(r);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(fit_count == 4'(exp), tag, fit_count, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=hang expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gnt_valid == 1'b0 && req_ready == 1'b0, "R1 in reset", {gnt_valid, req_ready}, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(req_ready == 1'b1 && gnt_valid == 1'b0, "R1 after reset", {gnt_valid, req_ready}, 1);
    chk_fit(256, 10, 3, "R1 R5 fit 256x10 empty");
    chk_fit(256, 11, 2, "R5 fit 256x11 empty");
    chk_fit(512, 16, 1, "R10 fit 512x16 empty");
    chk_fit(1, 0, 8, "R3 R10 fit 1x0 empty");
    chk_fit(0, 5, 0, "R2 fit zero threads");
    chk_fit(513, 0, 0, "R2 fit oversize");

    // Table walk: R6 slots, R4 thread cap, R2 range
    for (int i = 0; i < 6; i++) begin
      do_req(int'(VEC[i][21:12]), int'(VEC[i][11:4]), VEC[i][3], int'(VEC[i][2:0]),
             $sformatf("R2 R4 R6 vector %0d", i));
    end
    chk_fit(256, 10, 0, "R10 fit full threads");

    // R7 release returns resources
    do_rel(1);
    chk_fit(256, 10, 1, "R7 fit after release");
    do_req(256, 11, 1'b1, 1, "R5 R6 reuse slot1 at 11 regs");
    do_rel(0); do_rel(1); do_rel(2);
    chk_fit(1, 0, 8, "R7 all released");

    // R3 block limit
    for (int i = 0; i < 8; i++) do_req(1, 0, 1'b1, i, "R3 R6 fill slots");
    do_req(1, 0, 1'b0, 0, "R3 ninth refused");
    chk_fit(1, 0, 0, "R3 fit full");
    do_rel(3);
    chk_fit(1, 0, 1, "R7 one slot back");
    do_rel(3);
    chk_fit(1, 0, 1, "R7 unoccupied release ignored");
    do_req(1, 0, 1'b1, 3, "R6 refill slot3");

    // R8 same-cycle release and request
    @(negedge clk);
    rel_valid = 1'b1; rel_slot = 3'd6;
    req_valid = 1'b1; req_threads = 10'd1; req_regs = 8'd0;
    @(posedge clk); @(negedge clk);
    rel_valid = 1'b0; req_valid = 1'b0;
    check(gnt_valid && !gnt_ok, "R8 decision before release", {gnt_valid, gnt_ok}, 2);
    // R9 refused request not kept
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!gnt_valid, "R9 no grant without request", gnt_valid, 0);
    end
    chk_fit(1, 0, 1, "R8 release applied");
    do_req(1, 0, 1'b1, 6, "R8 freed slot granted");
    for (int i = 0; i < 8; i++) do_rel(i);

    // R4 thread cap
    do_req(512, 0, 1'b1, 0, "R4 512 threads");
    do_req(257, 0, 1'b0, 0, "R4 769 refused");
    do_req(256, 0, 1'b1, 1, "R4 exactly 768");
    do_rel(0); do_rel(1);

    // R5 register pool
    do_req(512, 16, 1'b1, 0, "R5 full pool");
    do_req(1, 0, 1'b1, 1, "R5 zero cost");
    do_req(1, 1, 1'b0, 0, "R5 one register over");
    chk_fit(1, 1, 0, "R5 fit pool exhausted");
    do_rel(0); do_rel(1);
    chk_fit(256, 10, 3, "R7 back to empty");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule